// File: doc/BRIEF.md
# Ethernet Test Frame Generator

This block is a programmable source of Ethernet test traffic. A processor sets it up through a small register port: the destination and source station addresses, the frame length, the number of frames to send, and two mode bits. One mode bit picks random frame lengths and the other picks pseudo-random payload bytes. A write to the start register launches the run. The block then sends frames back to back on a 64-bit streaming client interface toward a MAC transmitter. Each frame is emitted only as fast as the sink accepts beats.

Every frame is built as follows: six destination address bytes, then six source address bytes, then a two-byte length field, then payload. The frame check sequence is left to the MAC. A free-running 32-bit maximal-length LFSR supplies both the random lengths and the random payload words. It advances once for every accepted beat. A frame counter reports how many frames have finished since the last start. A stop command ends the run as soon as the frame in flight has finished.

Top module: `eth_testgen`

## Requirements
- R1: After reset the stream is idle (tx_valid low). Reads at offsets 0x00 (frame count), 0x0C (busy, bit 0) and 0x24 (sent count) return zero. The LFSR holds the seed 32'h2BAD_F00D.
- R2: Byte k of a frame goes out on beat k/8, lane k%8, with lane 0 on tx_data[63:56]. Bytes 0..5 are the destination address, most significant byte first. Bytes 6..11 are the source address in the same order. Bytes 12..13 are the frame length minus 14, big-endian. The address halves are written at 0x1C (destination bits 31:0), 0x20 (destination bits 47:32), 0x14 (source bits 31:0) and 0x18 (source bits 47:32).
- R3: When bit 0 of offset 0x08 is clear, payload byte k (k >= 14) equals k mod 256.
- R4: When bit 0 of offset 0x08 is set, a payload byte in lane j takes byte j (lane 0 = most significant) of the word {S, ~S}, where S is the LFSR state while that beat is presented. The LFSR is a right-shifting Galois register with mask 32'h8020_0003 (x^32+x^22+x^2+x+1) and advances on every accepted beat.
- R5: With bit 0 of offset 0x04 clear, every frame is L bytes long, where L is the value at offset 0x34 (bits 15:0) clamped to 64..1518. The last beat has tx_eop set and tx_empty = unused byte lanes. Lanes past the end carry zero. Every other beat has tx_empty = 0.
- R6: With bit 0 of offset 0x04 set, the length is taken when the first beat of the frame is accepted. It is S[10:0] raised to 64 when smaller and lowered to the clamped value at 0x34 when larger.
- R7: A beat is transferred only on a cycle with tx_valid and tx_ready both high. While tx_ready is low, every output holds its value.
- R8: A write to offset 0x0C while idle with a nonzero count at 0x00 sends exactly that many frames and then drops tx_valid. With a zero count the write does nothing.
- R9: A write to offset 0x10 while busy ends the run after the frame in flight. This includes a write made on the cycle that frame's last beat is accepted.
- R10: The sent count at 0x24 is cleared on launch, rises by one per accepted last beat, and holds while idle.
- R11: While busy, writes to the configuration registers and to start are ignored.
- R12: Offset 0x0C reads back the busy flag, which is high from launch until the run ends.
- R13: tx_sop is set on the first beat of each frame only. Frames follow each other with no idle cycle while busy.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 6 | Register byte offset (write and read) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| tx_data | output | 64 | Frame beat, first byte in bits 63:56 |
| tx_valid | output | 1 | Beat present |
| tx_ready | input | 1 | Sink accepts the beat |
| tx_sop | output | 1 | First beat of a frame |
| tx_eop | output | 1 | Last beat of a frame |
| tx_empty | output | 3 | Unused byte lanes on the last beat |

## Verification
The assertions assume a sink that may hold tx_ready low for any number of cycles. They also assume register writes can come at any time, including while a run is active. The stimulus follows both assumptions. It drives tx_ready always high, at random with a 3-in-4 chance, or at random with even odds. Configuration and start writes are issued in the middle of runs. A stop is timed so that it lands while frames are still in flight.

// File: rtl/tgen_pkg.sv
package tgen_pkg;

   localparam logic [5:0] OFS_COUNT  = 6'h00;
   localparam logic [5:0] OFS_RLEN   = 6'h04;
   localparam logic [5:0] OFS_RPAY   = 6'h08;
   localparam logic [5:0] OFS_START  = 6'h0C;
   localparam logic [5:0] OFS_STOP   = 6'h10;
   localparam logic [5:0] OFS_SRC_LO = 6'h14;
   localparam logic [5:0] OFS_SRC_HI = 6'h18;
   localparam logic [5:0] OFS_DST_LO = 6'h1C;
   localparam logic [5:0] OFS_DST_HI = 6'h20;
   localparam logic [5:0] OFS_SENT   = 6'h24;
   localparam logic [5:0] OFS_LEN    = 6'h34;

   localparam int unsigned HDR_BYTES = 14;

   typedef struct packed {
      logic [31:0] frames;
      logic        rnd_len;
      logic        rnd_pay;
      logic [47:0] src;
      logic [47:0] dst;
      logic [15:0] len;
   } tgen_cfg_t;

   function automatic logic [15:0] clamp_len(input logic [15:0] v,
                                             input logic [15:0] lo,
                                             input logic [15:0] hi);
      logic [15:0] r;
      r = v;
      if (v < lo) r = lo;
      else if (v > hi) r = hi;
      return r;
   endfunction

endpackage

// File: rtl/tgen_lfsr.sv
module tgen_lfsr #(
   parameter int unsigned W    = 32,
   parameter logic [W-1:0] TAPS = 32'h8020_0003,
   parameter logic [W-1:0] SEED = 32'h2BAD_F00D
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         adv,
   output logic [W-1:0] state
);

   if (SEED == '0) begin : g_bad_seed
      $error("tgen_lfsr: seed must be nonzero");
   end

   always_ff @(posedge clk) begin
      if (rst)      state <= SEED;
      else if (adv) state <= {1'b0, state[W-1:1]} ^ (state[0] ? TAPS : '0);
   end

   AST_LFSR_NONZERO: assert property (@(posedge clk) disable iff (rst)
      state != '0); // R4

endmodule

// File: rtl/tgen_regs.sv
module tgen_regs
   import tgen_pkg::*;
#(
   parameter int unsigned AW = 6
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            wr_en,
   input  logic [AW-1:0]   addr,
   input  logic [31:0]     wdata,
   input  logic            busy,
   input  logic [31:0]     sent_cnt,
   output tgen_cfg_t       cfg,
   output logic            start_wr,
   output logic            stop_wr,
   output logic [31:0]     rdata
);

   logic cfg_we;
   assign cfg_we   = wr_en && !busy;
   assign start_wr = wr_en && (addr == OFS_START);
   assign stop_wr  = wr_en && (addr == OFS_STOP);

   always_ff @(posedge clk) begin
      if (rst) begin
         cfg <= '0;
      end else if (cfg_we) begin
         case (addr)
            OFS_COUNT:  cfg.frames     <= wdata;
            OFS_RLEN:   cfg.rnd_len    <= wdata[0];
            OFS_RPAY:   cfg.rnd_pay    <= wdata[0];
            OFS_SRC_LO: cfg.src[31:0]  <= wdata;
            OFS_SRC_HI: cfg.src[47:32] <= wdata[15:0];
            OFS_DST_LO: cfg.dst[31:0]  <= wdata;
            OFS_DST_HI: cfg.dst[47:32] <= wdata[15:0];
            OFS_LEN:    cfg.len        <= wdata[15:0];
            default: ;
         endcase
      end
   end

   always_comb begin
      case (addr)
         OFS_COUNT:  rdata = cfg.frames;
         OFS_RLEN:   rdata = {31'b0, cfg.rnd_len};
         OFS_RPAY:   rdata = {31'b0, cfg.rnd_pay};
         OFS_START:  rdata = {31'b0, busy};
         OFS_SRC_LO: rdata = cfg.src[31:0];
         OFS_SRC_HI: rdata = {16'b0, cfg.src[47:32]};
         OFS_DST_LO: rdata = cfg.dst[31:0];
         OFS_DST_HI: rdata = {16'b0, cfg.dst[47:32]};
         OFS_SENT:   rdata = sent_cnt;
         OFS_LEN:    rdata = {16'b0, cfg.len};
         default:    rdata = '0;
      endcase
   end

   AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (rst)
      busy |=> $stable(cfg.len) && $stable(cfg.dst) && $stable(cfg.src)); // R11

endmodule

// File: rtl/tgen_seq.sv
module tgen_seq
   import tgen_pkg::*;
#(
   parameter int unsigned MIN_LEN = 64,
   parameter int unsigned MAX_LEN = 1518,
   parameter int unsigned BEAT_W  = 8,
   parameter int unsigned RND_W   = 11
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [31:0]       frames,
   input  logic              rnd_len,
   input  logic [15:0]       len_cfg,
   input  logic              start_wr,
   input  logic              stop_wr,
   input  logic              ready,
   input  logic              eop,
   input  logic [RND_W-1:0]  rnd_bits,
   output logic              busy,
   output logic              accept,
   output logic [BEAT_W-1:0] beat,
   output logic [15:0]       len_q,
   output logic [31:0]       sent_cnt
);

   logic [31:0] left;
   logic        stop_p;
   logic [15:0] cap, draw, next_len;
   logic        launch, frame_done, halt;

   assign cap      = clamp_len(len_cfg, 16'(MIN_LEN), 16'(MAX_LEN));
   assign draw     = clamp_len(16'(rnd_bits), 16'(MIN_LEN), cap);
   assign next_len = rnd_len ? draw : cap;

   assign accept     = busy && ready;
   assign launch     = start_wr && !busy && (frames != 32'd0);
   assign frame_done = accept && eop;
   assign halt       = frame_done && ((left == 32'd1) || stop_p || stop_wr);

   always_ff @(posedge clk) begin
      if (rst) begin
         busy     <= 1'b0;
         left     <= '0;
         beat     <= '0;
         len_q    <= 16'(MIN_LEN);
         stop_p   <= 1'b0;
         sent_cnt <= '0;
      end else if (launch) begin
         busy     <= 1'b1;
         left     <= frames;
         beat     <= '0;
         stop_p   <= 1'b0;
         sent_cnt <= '0;
      end else if (busy) begin
         if (stop_wr) stop_p <= 1'b1;
         if (accept) begin
            if (beat == '0) len_q <= next_len;
            if (eop) begin
               beat     <= '0;
               sent_cnt <= sent_cnt + 32'd1;
               left     <= left - 32'd1;
               if (halt) begin
                  busy   <= 1'b0;
                  stop_p <= 1'b0;
               end
            end else begin
               beat <= beat + 1'b1;
            end
         end
      end
   end

   AST_LEN_WINDOW: assert property (@(posedge clk) disable iff (rst)
      (busy && beat != '0) |-> (len_q >= 16'(MIN_LEN) && len_q <= 16'(MAX_LEN))); // R6
   AST_STOP_ENDS_RUN: assert property (@(posedge clk) disable iff (rst)
      (frame_done && (stop_p || stop_wr)) |=> !busy); // R9
   AST_SENT_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
      (!busy && !start_wr) |=> $stable(sent_cnt)); // R10
   AST_ZERO_COUNT_IDLE: assert property (@(posedge clk) disable iff (rst)
      (!busy && frames == 32'd0) |=> !busy); // R8

endmodule

// File: rtl/tgen_beat.sv
module tgen_beat
   import tgen_pkg::*;
#(
   parameter int unsigned DATA_W = 64,
   parameter int unsigned BEAT_W = 8
) (
   input  logic [BEAT_W-1:0]                 beat,
   input  logic [15:0]                       len_q,
   input  logic [47:0]                       src,
   input  logic [47:0]                       dst,
   input  logic                              rnd_pay,
   input  logic [DATA_W-1:0]                 rword,
   output logic [DATA_W-1:0]                 data,
   output logic                              sop,
   output logic                              eop,
   output logic [$clog2(DATA_W/8)-1:0]       empty
);

   localparam int unsigned BB = DATA_W / 8;
   localparam int unsigned EW = $clog2(BB);

   logic [15:0] base, stop_pos, typ, spare;

   assign base     = 16'(beat) << EW;
   assign stop_pos = base + 16'(BB);
   assign typ      = len_q - 16'(HDR_BYTES);
   assign spare    = stop_pos - len_q;
   assign sop      = (beat == '0);
   assign eop      = (beat != '0) && (stop_pos >= len_q);
   assign empty    = eop ? spare[EW-1:0] : '0;

   for (genvar j = 0; j < BB; j++) begin : g_lane
      logic [15:0] pos;
      logic [7:0]  pay, hdr0, hdr1;
      assign pos = base + 16'(j);
      assign pay = (pos >= len_q) ? 8'h00
                 : (rnd_pay ? rword[DATA_W-1-8*j -: 8] : pos[7:0]);
      if (j < 6) begin : g_h0_dst
         assign hdr0 = dst[47-8*j -: 8];
      end else begin : g_h0_src
         assign hdr0 = src[47-8*(j-6) -: 8];
      end
      if (j < 4) begin : g_h1_src
         assign hdr1 = src[31-8*j -: 8];
      end else if (j == 4) begin : g_h1_thi
         assign hdr1 = typ[15:8];
      end else if (j == 5) begin : g_h1_tlo
         assign hdr1 = typ[7:0];
      end else begin : g_h1_pay
         assign hdr1 = pay;
      end
      assign data[DATA_W-1-8*j -: 8] = (beat == '0) ? hdr0
                                     : (beat == BEAT_W'(1)) ? hdr1 : pay;
   end

endmodule

// File: rtl/eth_testgen.sv
module eth_testgen
   import tgen_pkg::*;
#(
   parameter int unsigned DATA_W    = 64,
   parameter int unsigned MIN_LEN   = 64,
   parameter int unsigned MAX_LEN   = 1518,
   parameter int unsigned LFSR_W    = 32,
   parameter logic [31:0] LFSR_TAPS = 32'h8020_0003,
   parameter logic [31:0] LFSR_SEED = 32'h2BAD_F00D
) (
   input  logic                        clk,
   input  logic                        rst,
   input  logic                        reg_wr,
   input  logic [5:0]                  reg_addr,
   input  logic [31:0]                 reg_wdata,
   output logic [31:0]                 reg_rdata,
   output logic [DATA_W-1:0]           tx_data,
   output logic                        tx_valid,
   input  logic                        tx_ready,
   output logic                        tx_sop,
   output logic                        tx_eop,
   output logic [$clog2(DATA_W/8)-1:0] tx_empty
);

   localparam int unsigned BB     = DATA_W / 8;
   localparam int unsigned BEAT_W = $clog2((MAX_LEN + BB - 1) / BB);
   localparam int unsigned RND_W  = $clog2(MAX_LEN + 1);

   if (DATA_W != 2 * LFSR_W) begin : g_bad_width
      $error("eth_testgen: DATA_W must be twice LFSR_W");
   end
   if (MIN_LEN < HDR_BYTES + 2 || MIN_LEN <= BB || MIN_LEN > MAX_LEN) begin : g_bad_min
      $error("eth_testgen: MIN_LEN out of range");
   end
   if (RND_W > LFSR_W || MAX_LEN > 16'hFFFF) begin : g_bad_max
      $error("eth_testgen: MAX_LEN out of range");
   end

   tgen_cfg_t             cfg;
   logic                  start_wr, stop_wr, busy, accept;
   logic [31:0]           sent_cnt;
   logic [BEAT_W-1:0]     beat;
   logic [15:0]           len_q;
   logic [LFSR_W-1:0]     lfsr;

   tgen_regs #(.AW(6)) u_regs (
      .clk(clk), .rst(rst), .wr_en(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
      .busy(busy), .sent_cnt(sent_cnt), .cfg(cfg), .start_wr(start_wr),
      .stop_wr(stop_wr), .rdata(reg_rdata)
   );

   tgen_lfsr #(.W(LFSR_W), .TAPS(LFSR_TAPS[LFSR_W-1:0]), .SEED(LFSR_SEED[LFSR_W-1:0])) u_lfsr (
      .clk(clk), .rst(rst), .adv(accept), .state(lfsr)
   );

   tgen_seq #(.MIN_LEN(MIN_LEN), .MAX_LEN(MAX_LEN), .BEAT_W(BEAT_W), .RND_W(RND_W)) u_seq (
      .clk(clk), .rst(rst), .frames(cfg.frames), .rnd_len(cfg.rnd_len),
      .len_cfg(cfg.len), .start_wr(start_wr), .stop_wr(stop_wr), .ready(tx_ready),
      .eop(tx_eop), .rnd_bits(lfsr[RND_W-1:0]), .busy(busy), .accept(accept),
      .beat(beat), .len_q(len_q), .sent_cnt(sent_cnt)
   );

   tgen_beat #(.DATA_W(DATA_W), .BEAT_W(BEAT_W)) u_beat (
      .beat(beat), .len_q(len_q), .src(cfg.src), .dst(cfg.dst),
      .rnd_pay(cfg.rnd_pay), .rword({lfsr, ~lfsr}), .data(tx_data),
      .sop(tx_sop), .eop(tx_eop), .empty(tx_empty)
   );

   assign tx_valid = busy;

   AST_HOLD_ON_STALL: assert property (@(posedge clk) disable iff (rst)
      (tx_valid && !tx_ready) |=> tx_valid && $stable(tx_data) && $stable(tx_sop)
                                  && $stable(tx_eop) && $stable(tx_empty)); // R7
   AST_SOP_AFTER_EOP: assert property (@(posedge clk) disable iff (rst)
      (tx_valid && tx_ready && tx_eop) |=> (!tx_valid || tx_sop)); // R13
   AST_EMPTY_MIDFRAME: assert property (@(posedge clk) disable iff (rst)
      (tx_valid && !tx_eop) |-> (tx_empty == '0)); // R5
   AST_SOP_NOT_EOP: assert property (@(posedge clk) disable iff (rst)
      tx_valid |-> !(tx_sop && tx_eop)); // R13

endmodule

// File: tb/eth_testgen_bench.sv
module eth_testgen_bench;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        reg_wr = 1'b0;
   logic [5:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic [63:0] tx_data;
   logic        tx_valid, tx_sop, tx_eop;
   logic        tx_ready = 1'b0;
   logic [2:0]  tx_empty;

   always #5 clk = ~clk;

   eth_testgen u_eth_testgen (
      .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tx_data(tx_data),
      .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_sop(tx_sop),
      .tx_eop(tx_eop), .tx_empty(tx_empty)
   );

   int    n_chk = 0, n_fail = 0, cyc = 0, rdy_mode = 0, dut_frames = 0;
   string cur_req = "R1";

   // behavioural reference state
   bit          m_busy, m_stopp;
   int unsigned m_left, m_k, m_L, m_sent;
   logic [31:0] m_S;
   logic [31:0] c_frames;
   bit          c_rl, c_rp;
   logic [47:0] c_src, c_dst;
   logic [15:0] c_len;

   function automatic logic [31:0] lfsr_next(input logic [31:0] s);
      return s[0] ? ((s >> 1) ^ 32'h8020_0003) : (s >> 1);
   endfunction

   function automatic int unsigned clampv(input int unsigned v, input int unsigned lo, input int unsigned hi);
      if (v < lo) return lo;
      if (v > hi) return hi;
      return v;
   endfunction

   function automatic logic [7:0] exp_byte(input int unsigned p);
      logic [47:0] t;
      logic [63:0] w;
      int unsigned plen;
      plen = m_L - 14;
      if (p < 6)  begin t = c_dst >> (8 * (5 - p));  return t[7:0]; end
      if (p < 12) begin t = c_src >> (8 * (11 - p)); return t[7:0]; end
      if (p == 12) return plen[15:8];
      if (p == 13) return plen[7:0];
      if (p >= m_L) return 8'h00;
      if (c_rp) begin
         w = {m_S, ~m_S} >> (8 * (7 - (p % 8)));
         return w[7:0];
      end
      return p[7:0];
   endfunction

   task automatic check(input bit ok, input string req, input string what,
                        input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s act %h exp %h (t=%0t)", req, what, act, exp, $time);
      end
   endtask

   // reference model update at the active edge
   always @(posedge clk) begin
      bit acc, was_busy, st_hit, done;
      cyc++;
      if (rst) begin
         m_busy = 0; m_stopp = 0; m_left = 0; m_k = 0; m_L = 64; m_sent = 0;
         m_S = 32'h2BAD_F00D; c_frames = 0; c_rl = 0; c_rp = 0;
         c_src = 0; c_dst = 0; c_len = 0;
      end else begin
         was_busy = m_busy;
         acc      = m_busy && tx_ready;
         st_hit   = reg_wr && reg_addr == 6'h10;
         if (acc) begin
            if (m_k == 0)
               m_L = c_rl ? clampv(m_S[10:0], 64, clampv(c_len, 64, 1518))
                          : clampv(c_len, 64, 1518);
            done = (m_k != 0) && (m_k * 8 + 8 >= m_L);
            m_S = lfsr_next(m_S);
            if (done) begin
               m_sent++; m_left--; m_k = 0;
               if (m_left == 0 || m_stopp || st_hit) begin m_busy = 0; m_stopp = 0; end
            end else m_k++;
         end
         if (m_busy && st_hit) m_stopp = 1;
         if (reg_wr && !was_busy) begin
            case (reg_addr)
               6'h00: c_frames = reg_wdata;
               6'h04: c_rl = reg_wdata[0];
               6'h08: c_rp = reg_wdata[0];
               6'h14: c_src[31:0] = reg_wdata;
               6'h18: c_src[47:32] = reg_wdata[15:0];
               6'h1C: c_dst[31:0] = reg_wdata;
               6'h20: c_dst[47:32] = reg_wdata[15:0];
               6'h34: c_len = reg_wdata[15:0];
               6'h0C: if (c_frames != 0) begin
                  m_busy = 1; m_left = c_frames; m_k = 0; m_sent = 0; m_stopp = 0;
               end
               default: ;
            endcase
         end
      end
      if (cyc > 150000) begin
         n_fail++;
         $display("FAIL R8 watchdog expired act %0d cycles exp below 150000", cyc);
         $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
         $finish;
      end
   end

   // per-cycle comparison away from the edge, then next ready value
   always @(negedge clk) begin
      logic [63:0] ed;
      bit          ee;
      logic [2:0]  em;
      if (!rst) begin
         check(tx_valid === m_busy, cur_req, "valid", 64'(tx_valid), 64'(m_busy));
         if (m_busy) begin
            for (int j = 0; j < 8; j++) ed[63-8*j -: 8] = exp_byte(m_k * 8 + j);
            ee = (m_k != 0) && (m_k * 8 + 8 >= m_L);
            em = ee ? 3'(m_k * 8 + 8 - m_L) : 3'd0;
            check(tx_data === ed, cur_req, "data", tx_data, ed);
            check(tx_sop === (m_k == 0), "R13", "sop", 64'(tx_sop), 64'(m_k == 0));
            check(tx_eop === ee, "R5", "eop", 64'(tx_eop), 64'(ee));
            check(tx_empty === em, "R5", "empty", 64'(tx_empty), 64'(em));
         end
      end
      case (rdy_mode)
         0:       tx_ready = 1'b1;
         1:       tx_ready = ($urandom % 4) != 0;
         default: tx_ready = ($urandom % 2) != 0;
      endcase
      if (tx_valid && tx_ready && tx_eop) dut_frames++;
   end

   task automatic wr(input logic [5:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [5:0] a, output logic [31:0] d);
      @(negedge clk);
      reg_addr = a;
      #1 d = reg_rdata;
   endtask

   task automatic wait_idle();
      int n = 0;
      do begin @(negedge clk); n++; end while ((tx_valid || m_busy) && n < 30000);
      check(!tx_valid, "R8", "run did not end", 64'(tx_valid), 64'(0));
   endtask

   task automatic run(input int frames, input string req);
      logic [31:0] d;
      int f0;
      cur_req = req;
      wr(6'h00, frames);
      f0 = dut_frames;
      wr(6'h0C, 1);
      wait_idle();
      check(dut_frames - f0 == frames, "R8", "frames sent", 64'(dut_frames - f0), 64'(frames));
      rd(6'h24, d);
      check(d == frames, "R10", "sent count", 64'(d), 64'(frames));
   endtask

   initial begin
      logic [31:0] d;
      int f0;
      repeat (4) @(negedge clk);
      rst = 1'b0;
      // R1 reset state
      rd(6'h00, d); check(d == 0, "R1", "count reg", 64'(d), 0);
      rd(6'h0C, d); check(d == 0, "R1", "busy reg", 64'(d), 0);
      rd(6'h24, d); check(d == 0, "R1", "sent reg", 64'(d), 0);
      check(!tx_valid, "R1", "valid after reset", 64'(tx_valid), 0);

      // R8 zero count launch does nothing
      cur_req = "R8";
      wr(6'h0C, 1);
      repeat (10) @(negedge clk);
      rd(6'h0C, d); check(d == 0, "R8", "busy with zero count", 64'(d), 0);

      // addresses and fixed incrementing frames
      wr(6'h1C, 32'h2233_4455); wr(6'h20, 32'h0011);
      wr(6'h14, 32'hCCDD_EEFF); wr(6'h18, 32'h0AAB);
      wr(6'h34, 100);
      rdy_mode = 0;
      run(3, "R2/R3");
      rdy_mode = 1; wr(6'h34, 67);
      run(2, "R5/R7");
      wr(6'h34, 10);
      run(2, "R5");                         // clamps up to 64
      wr(6'h08, 1); wr(6'h34, 2000); rdy_mode = 2;
      run(1, "R4/R7");                      // clamps down to 1518
      wr(6'h04, 1); wr(6'h34, 1518); rdy_mode = 1;
      run(10, "R6/R4");
      wr(6'h34, 200);
      run(6, "R6");
      wr(6'h04, 0); wr(6'h08, 0);

      // R11 / R12 writes during a run
      cur_req = "R11";
      wr(6'h34, 80); wr(6'h00, 5);
      f0 = dut_frames;
      wr(6'h0C, 1);
      rd(6'h0C, d); check(d == 1, "R12", "busy during run", 64'(d), 1);
      wr(6'h34, 300); wr(6'h1C, 32'hDEAD_BEEF); wr(6'h08, 1); wr(6'h0C, 1);
      wait_idle();
      check(dut_frames - f0 == 5, "R11", "frames after restart attempt", 64'(dut_frames - f0), 5);
      rd(6'h34, d); check(d == 80, "R11", "length kept", 64'(d), 80);
      rd(6'h1C, d); check(d == 32'h2233_4455, "R11", "dst kept", 64'(d), 64'h2233_4455);
      rd(6'h0C, d); check(d == 0, "R12", "busy after run", 64'(d), 0);

      // R9 stop in the middle of a long run
      cur_req = "R9";
      rdy_mode = 0;
      wr(6'h34, 64); wr(6'h00, 1000);
      wr(6'h0C, 1);
      repeat (30) @(negedge clk);
      wr(6'h10, 1);
      wait_idle();
      rd(6'h24, d);
      check(d < 1000 && d == m_sent, "R9", "frames before stop", 64'(d), 64'(m_sent));
      repeat (5) @(negedge clk);
      rd(6'h24, d); check(d == m_sent, "R10", "sent held idle", 64'(d), 64'(m_sent));

      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   end

endmodule